// File: doc/BRIEF.md
# Three-Wire Serial Configuration Register Loader

This block receives configuration words over a three-wire serial link (serial clock, serial data, active-low load strobe) and keeps a bank of eight 8-bit control registers. It holds the gain and offset words for three colour channels and two mode registers. The serial pins share package pads with a parallel data output bus. A line-sync input decides who owns those pads: while it is high the bus is released and the port listens; while it is low, serial activity is ignored.

A write starts when the strobe falls. Each rising edge of the serial clock shifts in one bit. The first three bits form the register address, most significant bit first, and the next eight bits form the data. The word is stored when the strobe rises, but only if at least eleven serial clocks arrived. Clocks after the eleventh do not change the word. The mode register also carries two bits that act at once. The digital-reset bit restores every register to its power-up value. Clearing the power-down bit while it is set also clears the two-bit signal-configuration field.

The serial clock, data, strobe and sync are brought into the system clock domain through a synchroniser chain. Edges are detected after the chain. A bit counter stops at eleven.

Top module: `serial_cfg_loader`

## Requirements
- R1: `bus_oe_o` is 0 whenever `sync_i` is 1 and 1 whenever `sync_i` is 0, with no clock delay.
- R2: After reset, every gain output is 0, every offset output is 8'h40, and every field of both mode registers is 0.
- R3: A word is 11 bits, sampled on rising serial-clock edges. Bits 1-3 are the address and bits 4-11 are the data, both MSB first. It is stored on the strobe's rising edge. Address map: 0 red gain, 1 red offset, 2 green gain, 3 green offset, 4 blue gain, 5 blue offset, 6 mode, 7 mode/test.
- R4: If fewer than 11 serial-clock rises occur between the strobe falling and rising, no register changes.
- R5: Serial-clock rises after the eleventh in one window are ignored; only the first 11 bits are used.
- R6: While sync is low, strobe and clock activity are ignored. If sync falls while a window is open, that window is abandoned and no write happens.
- R7: A gain register keeps data bits 7:2 as its 6-bit gain. Data bits 1:0 have no effect.
- R8: A write to address 6 with data bit 6 set (digital reset) returns all eight registers to their power-up values, including the mode register itself.
- R9: A write to address 6 with bit 7 clear, made while the stored bit 7 (power-down) is set, stores the word with bits 1:0 (signal configuration) forced to 00. Every other register keeps its value.
- R10: With the default two synchroniser stages, a committed value appears on the outputs after the third rising system-clock edge that follows the strobe's rising input edge, and not earlier.
- R11: Mode register fields: bit 7 power-down, bit 5 top-reference external, bit 4 DC-reference external, bit 3 AC coupling, bit 2 inversion, bits 1:0 signal configuration. Mode/test register fields: bit 7 test-5, bit 6 output disable, bit 5 offset range, bit 4 sensor reference, bits 3:0 test select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Line sync; high enables the serial port |
| sclk_i | input | 1 | Serial clock |
| sdata_i | input | 1 | Serial data |
| ld_n_i | input | 1 | Active-low load strobe |
| bus_oe_o | output | 1 | Output enable for the shared parallel bus |
| red_gain_o | output | 6 | Red gain |
| red_ofs_o | output | 8 | Red offset |
| grn_gain_o | output | 6 | Green gain |
| grn_ofs_o | output | 8 | Green offset |
| blu_gain_o | output | 6 | Blue gain |
| blu_ofs_o | output | 8 | Blue offset |
| pwr_down_o | output | 1 | Power-down field |
| ref_top_ext_o | output | 1 | External top reference select |
| dcref_ext_o | output | 1 | External DC reference select |
| ac_couple_o | output | 1 | AC coupling select |
| invert_o | output | 1 | Signal inversion select |
| chan_cfg_o | output | 2 | Signal configuration |
| test_msb_o | output | 1 | Test-5 field |
| out_dis_o | output | 1 | Output disable field |
| ofs_range_o | output | 1 | Offset range select |
| cis_ref_o | output | 1 | Sensor reference circuit enable |
| test_sel_o | output | 4 | Test select field |

## Verification
The bus enable follows sync at once and is checked at the same time step as the sync change. A stored value needs two synchroniser edges plus one register edge after the strobe rises, so it lands on the third rising edge. The bench checks the registers one clock before that edge, where the old value must still hold, and on that edge. Every other write is checked only after a settling gap of six clocks. The serial levels are held three clocks each so that every edge survives the synchroniser.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int ADDR_W    = 3;
  localparam int DATA_W    = 8;
  localparam int NUM_REGS  = 1 << ADDR_W;
  localparam int WORD_BITS = ADDR_W + DATA_W;
  localparam int CNT_W     = $clog2(WORD_BITS + 1);
  localparam int GAIN_W    = 6;
  localparam int MODE_IDX  = 6;
  localparam int TEST_IDX  = 7;
  localparam int PD_BIT    = 7;
  localparam int DRST_BIT  = 6;
  localparam int CFG_W     = 2;
  localparam logic [DATA_W-1:0] OFS_INIT = 8'h40;

  function automatic logic is_gain(input int idx);
    return (idx < MODE_IDX) && ((idx % 2) == 0);
  endfunction

  function automatic logic [DATA_W-1:0] init_value(input int idx);
    return ((idx < MODE_IDX) && ((idx % 2) == 1)) ? OFS_INIT : '0;
  endfunction

  // Value stored by a committed write to register idx, given its old value.
  function automatic logic [DATA_W-1:0] write_value(input int idx,
                                                    input logic [DATA_W-1:0] old_v,
                                                    input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] v;
    v = d;
    if (is_gain(idx))
      v[DATA_W-GAIN_W-1:0] = '0;
    if (idx == MODE_IDX && old_v[PD_BIT] && !d[PD_BIT])
      v[CFG_W-1:0] = '0;
    return v;
  endfunction
endpackage

// File: rtl/sc_in_sync.sv
module sc_in_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      chain[s] <= RST_VAL;
        else if (s == 0) chain[s] <= d_i;
        else             chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/sc_word_rx.sv
module sc_word_rx
  import sc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 active_i,
  input  logic                 sclk_i,
  input  logic                 sdata_i,
  input  logic                 ld_n_i,
  output logic                 commit_o,
  output logic [ADDR_W-1:0]    addr_o,
  output logic [DATA_W-1:0]    data_o,
  output logic [CNT_W-1:0]     bit_cnt_o,
  output logic [WORD_BITS-1:0] shift_o,
  output logic                 ev_ld_fall_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_BITS);

  logic sclk_d, ld_d, open_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [WORD_BITS-1:0] sh_q;
  logic ev_sclk_rise, ev_ld_fall, ev_ld_rise;

  assign ev_sclk_rise = sclk_i & ~sclk_d;
  assign ev_ld_fall   = ~ld_n_i & ld_d;
  assign ev_ld_rise   = ld_n_i & ~ld_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      ld_d   <= 1'b1;
    end else begin
      sclk_d <= sclk_i;
      ld_d   <= ld_n_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
    end else if (!active_i) begin
      open_q <= 1'b0;
    end else if (ev_ld_fall) begin
      open_q <= 1'b1;
      cnt_q  <= '0;
    end else if (ev_ld_rise) begin
      open_q <= 1'b0;
    end else if (open_q && ev_sclk_rise && cnt_q < FULL) begin
      sh_q  <= {sh_q[WORD_BITS-2:0], sdata_i};
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign commit_o     = active_i & open_q & ev_ld_rise & (cnt_q == FULL);
  assign addr_o       = sh_q[WORD_BITS-1:DATA_W];
  assign data_o       = sh_q[DATA_W-1:0];
  assign bit_cnt_o    = cnt_q;
  assign shift_o      = sh_q;
  assign ev_ld_fall_o = ev_ld_fall;
endmodule

// File: rtl/sc_reg_bank.sv
module sc_reg_bank
  import sc_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         commit_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [DATA_W-1:0]            data_i,
  output logic [NUM_REGS*DATA_W-1:0]   regs_o
);
  logic clear_all;
  assign clear_all = commit_i && (addr_i == ADDR_W'(MODE_IDX)) && data_i[DRST_BIT];

  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          q <= init_value(i);
        else if (clear_all)
          q <= init_value(i);
        else if (commit_i && addr_i == ADDR_W'(i))
          q <= write_value(i, q, data_i);
      end
      assign regs_o[i*DATA_W +: DATA_W] = q;
    end
  endgenerate
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import sc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_i,
  input  logic       sclk_i,
  input  logic       sdata_i,
  input  logic       ld_n_i,
  output logic       bus_oe_o,
  output logic [5:0] red_gain_o,
  output logic [7:0] red_ofs_o,
  output logic [5:0] grn_gain_o,
  output logic [7:0] grn_ofs_o,
  output logic [5:0] blu_gain_o,
  output logic [7:0] blu_ofs_o,
  output logic       pwr_down_o,
  output logic       ref_top_ext_o,
  output logic       dcref_ext_o,
  output logic       ac_couple_o,
  output logic       invert_o,
  output logic [1:0] chan_cfg_o,
  output logic       test_msb_o,
  output logic       out_dis_o,
  output logic       ofs_range_o,
  output logic       cis_ref_o,
  output logic [3:0] test_sel_o
);
  logic [3:0] pins_s;
  logic       sync_lvl, ld_lvl, sclk_lvl, sdata_lvl;
  logic       commit_w, ld_fall_w;
  logic [ADDR_W-1:0]    wr_addr_w;
  logic [DATA_W-1:0]    wr_data_w;
  logic [CNT_W-1:0]     bit_cnt_w;
  logic [WORD_BITS-1:0] shift_w;
  logic [NUM_REGS*DATA_W-1:0] regs_w;
  logic [DATA_W-1:0] mode_r, test_r;

  // Shared pads belong to the serial port while sync is high.
  assign bus_oe_o = ~sync_i;

  sc_in_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({sync_i, ld_n_i, sclk_i, sdata_i}),
    .q_o(pins_s)
  );
  assign {sync_lvl, ld_lvl, sclk_lvl, sdata_lvl} = pins_s;

  sc_word_rx u_rx (
    .clk(clk), .rst_n(rst_n),
    .active_i(sync_lvl), .sclk_i(sclk_lvl), .sdata_i(sdata_lvl), .ld_n_i(ld_lvl),
    .commit_o(commit_w), .addr_o(wr_addr_w), .data_o(wr_data_w),
    .bit_cnt_o(bit_cnt_w), .shift_o(shift_w), .ev_ld_fall_o(ld_fall_w)
  );

  sc_reg_bank u_bank (
    .clk(clk), .rst_n(rst_n),
    .commit_i(commit_w), .addr_i(wr_addr_w), .data_i(wr_data_w),
    .regs_o(regs_w)
  );

  assign red_gain_o = regs_w[0*DATA_W+2 +: GAIN_W];
  assign red_ofs_o  = regs_w[1*DATA_W   +: DATA_W];
  assign grn_gain_o = regs_w[2*DATA_W+2 +: GAIN_W];
  assign grn_ofs_o  = regs_w[3*DATA_W   +: DATA_W];
  assign blu_gain_o = regs_w[4*DATA_W+2 +: GAIN_W];
  assign blu_ofs_o  = regs_w[5*DATA_W   +: DATA_W];
  assign mode_r     = regs_w[MODE_IDX*DATA_W +: DATA_W];
  assign test_r     = regs_w[TEST_IDX*DATA_W +: DATA_W];

  assign pwr_down_o    = mode_r[PD_BIT];
  assign ref_top_ext_o = mode_r[5];
  assign dcref_ext_o   = mode_r[4];
  assign ac_couple_o   = mode_r[3];
  assign invert_o      = mode_r[2];
  assign chan_cfg_o    = mode_r[CFG_W-1:0];
  assign test_msb_o    = test_r[7];
  assign out_dis_o     = test_r[6];
  assign ofs_range_o   = test_r[5];
  assign cis_ref_o     = test_r[4];
  assign test_sel_o    = test_r[3:0];
endmodule

// File: rtl/sc_loader_chk.sv
module sc_loader_chk
  import sc_pkg::*;
(
  input logic                       clk,
  input logic                       rst_n,
  input logic                       sync_lvl,
  input logic                       commit_w,
  input logic                       ld_fall_w,
  input logic [ADDR_W-1:0]          wr_addr_w,
  input logic [DATA_W-1:0]          wr_data_w,
  input logic [CNT_W-1:0]           bit_cnt_w,
  input logic [WORD_BITS-1:0]       shift_w,
  input logic [NUM_REGS*DATA_W-1:0] regs_w,
  input logic                       pwr_down_o,
  input logic [1:0]                 chan_cfg_o
);
  // R4: registers only move on the edge right after a full-word commit
  a_r4_change_only_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs_w) |-> $past(commit_w));

  // R5: counter stops at the word length
  a_r5_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt_w <= CNT_W'(WORD_BITS));

  // R5: once full, the shift register holds until a new window opens
  a_r5_no_shift_after_full: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_cnt_w == CNT_W'(WORD_BITS) && !ld_fall_w) |=> $stable(shift_w));

  // R6: nothing is written while the port is idle
  a_r6_idle_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_lvl |-> !commit_w);

  // R8: digital reset leaves mode register at zero and offsets at power-up
  a_r8_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_w && wr_addr_w == ADDR_W'(MODE_IDX) && wr_data_w[DRST_BIT])
    |=> (regs_w[MODE_IDX*DATA_W +: DATA_W] == '0 && regs_w[DATA_W +: DATA_W] == OFS_INIT));

  // R9: leaving power-down clears the signal configuration
  a_r9_release_clears_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_w && wr_addr_w == ADDR_W'(MODE_IDX) && !wr_data_w[DRST_BIT]
     && !wr_data_w[PD_BIT] && pwr_down_o) |=> (chan_cfg_o == 2'b00));
endmodule

bind serial_cfg_loader sc_loader_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sync_lvl(sync_lvl), .commit_w(commit_w),
  .ld_fall_w(ld_fall_w), .wr_addr_w(wr_addr_w), .wr_data_w(wr_data_w),
  .bit_cnt_w(bit_cnt_w), .shift_w(shift_w), .regs_w(regs_w),
  .pwr_down_o(pwr_down_o), .chan_cfg_o(chan_cfg_o)
);

// File: tb/serial_cfg_loader_tb_top.sv
module serial_cfg_loader_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sync_i = 1'b0, sclk_i = 1'b0, sdata_i = 1'b0, ld_n_i = 1'b1;
  logic bus_oe_o;
  logic [5:0] red_gain_o, grn_gain_o, blu_gain_o;
  logic [7:0] red_ofs_o, grn_ofs_o, blu_ofs_o;
  logic pwr_down_o, ref_top_ext_o, dcref_ext_o, ac_couple_o, invert_o;
  logic [1:0] chan_cfg_o;
  logic test_msb_o, out_dis_o, ofs_range_o, cis_ref_o;
  logic [3:0] test_sel_o;

  int total = 0, bad = 0, cycles = 0;
  logic [7:0] mdl [8];

  always #4 clk = ~clk;

  serial_cfg_loader dut_i (.*);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      bad = bad + 1; total = total + 1;
      $display("FAIL watchdog: run did not finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] act_vec();
    return {6'd0, red_gain_o, red_ofs_o, grn_gain_o, grn_ofs_o, blu_gain_o, blu_ofs_o,
            pwr_down_o, 1'b0, ref_top_ext_o, dcref_ext_o, ac_couple_o, invert_o, chan_cfg_o,
            test_msb_o, out_dis_o, ofs_range_o, cis_ref_o, test_sel_o};
  endfunction

  function automatic logic [63:0] exp_vec();
    return {6'd0, mdl[0][7:2], mdl[1], mdl[2][7:2], mdl[3], mdl[4][7:2], mdl[5],
            mdl[6][7], 1'b0, mdl[6][5:0], mdl[7]};
  endfunction

  task automatic model_init();
    for (int i = 0; i < 8; i++) mdl[i] = (i == 1 || i == 3 || i == 5) ? 8'd64 : 8'd0;
  endtask

  task automatic model_write(input int a, input logic [7:0] d);
    if (a == 6 && d[6]) model_init();
    else if (a == 6 && mdl[6][7] && !d[7]) mdl[6] = {d[7:2], 2'b00};
    else if (a < 6 && a % 2 == 0) mdl[a] = {d[7:2], 2'b00};
    else mdl[a] = d;
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Sends nclk bits; bits past the 11th are the inverse of the word bits.
  task automatic send(input int a, input logic [7:0] d, input int nclk, input bit finish);
    logic [10:0] w;
    w = {a[2:0], d};
    ld_n_i = 1'b0; ticks(4);
    for (int i = 0; i < nclk; i++) begin
      sdata_i = (i < 11) ? w[10 - i] : ~w[i % 11];
      ticks(3); sclk_i = 1'b1; ticks(3); sclk_i = 1'b0;
    end
    ticks(3);
    if (finish) begin ld_n_i = 1'b1; ticks(6); end
  endtask

  initial begin
    model_init();
    ticks(3); rst_n = 1'b1; ticks(2);
    check("R2 power-up values", act_vec(), exp_vec());
    check("R1 bus driven while sync low", {63'd0, bus_oe_o}, 64'd1);
    sync_i = 1'b1; #1;
    check("R1 bus released while sync high", {63'd0, bus_oe_o}, 64'd0);
    ticks(4);

    // R3 sweep over all addresses and several data patterns
    for (int a = 0; a < 8; a++)
      for (int k = 0; k < 8; k++) begin
        logic [7:0] d;
        d = 8'((a * 29 + k * 53 + 7) % 256);
        send(a, d, 11, 1'b1);
        model_write(a, d);
        check("R3 write sweep", act_vec(), exp_vec());
      end

    // R11 fields at their positions
    send(7, 8'hA5, 11, 1'b1); model_write(7, 8'hA5);
    check("R11 test fields", {59'd0, test_msb_o, out_dis_o, ofs_range_o, cis_ref_o, 1'b0},
          {59'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0});
    check("R11 test select", {60'd0, test_sel_o}, 64'h5);
    send(6, 8'h2E, 11, 1'b1); model_write(6, 8'h2E);
    check("R11 mode fields", {58'd0, pwr_down_o, ref_top_ext_o, dcref_ext_o, ac_couple_o, invert_o,
          1'b0}, {58'd0, 6'b010110});
    check("R11 signal config", {62'd0, chan_cfg_o}, 64'd2);

    // R4 short words
    send(1, 8'h13, 10, 1'b1);
    check("R4 ten clocks no write", act_vec(), exp_vec());
    send(3, 8'h77, 0, 1'b1);
    check("R4 zero clocks no write", act_vec(), exp_vec());

    // R5 extra clocks ignored
    send(5, 8'h3C, 13, 1'b1); model_write(5, 8'h3C);
    check("R5 thirteen clocks", act_vec(), exp_vec());
    send(0, 8'hC4, 20, 1'b1); model_write(0, 8'hC4);
    check("R5 twenty clocks", act_vec(), exp_vec());

    // R7 gain low bits ignored
    send(2, 8'b1011_0111, 11, 1'b1); model_write(2, 8'b1011_0111);
    check("R7 gain upper six", {58'd0, grn_gain_o}, 64'b101101);

    // R6 sync low blocks writes
    sync_i = 1'b0; ticks(4);
    send(1, 8'hEE, 11, 1'b1);
    check("R6 write while sync low", act_vec(), exp_vec());
    sync_i = 1'b1; ticks(4);
    send(3, 8'h99, 11, 1'b0);
    sync_i = 1'b0; ticks(4); ld_n_i = 1'b1; ticks(4);
    sync_i = 1'b1; ticks(6);
    check("R6 window abandoned on sync fall", act_vec(), exp_vec());

    // R8 digital reset
    send(4, 8'hFC, 11, 1'b1); model_write(4, 8'hFC);
    send(6, 8'h40, 11, 1'b1); model_write(6, 8'h40);
    check("R8 digital reset restores power-up", act_vec(), exp_vec());
    check("R8 blue gain back to zero", {58'd0, blu_gain_o}, 64'd0);

    // R9 power-down release
    send(1, 8'h5A, 11, 1'b1); model_write(1, 8'h5A);
    send(6, 8'h83, 11, 1'b1); model_write(6, 8'h83);
    check("R9 power-down set", {62'd0, pwr_down_o, chan_cfg_o[0]}, 64'd3);
    send(6, 8'h03, 11, 1'b1); model_write(6, 8'h03);
    check("R9 release clears config", {62'd0, chan_cfg_o}, 64'd0);
    check("R9 others retained", act_vec(), exp_vec());
    send(6, 8'h02, 11, 1'b1); model_write(6, 8'h02);
    check("R9 config written after release", {62'd0, chan_cfg_o}, 64'd2);

    // R10 latency
    send(7, 8'h3F, 11, 1'b0);
    ld_n_i = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R10 unchanged after two edges", act_vec(), exp_vec());
    model_write(7, 8'h3F);
    @(posedge clk); @(negedge clk);
    check("R10 updated on third edge", act_vec(), exp_vec());

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule